// File: doc/BRIEF.md
# Field-Periodic Polynomial Deflection Waveform Generator

This block generates one deflection waveform per field by forward differencing. The waveform is a polynomial in a field position that sweeps from 0 to 1 over one field and is expanded around mid-field. A host computes one 12-bit start value per polynomial order and writes it into a bank of holding registers. At every field-start pulse, a cascade of accumulators is reloaded from that bank. On every line-step pulse, each accumulator then absorbs the value of the next higher-order accumulator. The order-0 accumulator carries the waveform sample.

A parameter selects between two profiles. The cubic profile is meant for vertical deflection. It uses four accumulators, multiplies its output by an unsigned beam-current scale factor, and drives a registered request for low output impedance while the retrace input is high. The quartic profile is meant for east-west correction. It uses five accumulators, has no scaling, and holds the impedance request low.

The accumulators are wider than the start values, so intermediate results have headroom. Internal arithmetic wraps at the accumulator width. The sample seen at the output is clipped into the signed 12-bit range.

Top module: `pwg_deflect_gen`

## Requirements
- R1: After reset, all start registers and accumulators are zero, so `wave_o` and `low_z_o` read 0.
- R2: A cycle with `field_start_i` high loads accumulator k with the sign-extended start value of order k. In the following cycle, `wave_o` shows the order-0 start value (scaled as in R7 for the cubic profile).
- R3: A cycle with `line_step_i` high and `field_start_i` low updates all accumulators at once. Accumulator k becomes its old value plus the old value of accumulator k+1, and the highest-order accumulator keeps its value. Accumulators are 20 bits and wrap as two's complement.
- R4: When `field_start_i` and `line_step_i` are high in the same cycle, only the reload of R2 takes place.
- R5: A write with `cfg_we_i` high stores `cfg_wdata_i` (signed, two's complement) as the start value of order `cfg_addr_i`. It does not change the running waveform until the next field start. A write in the same cycle as a field start is not used by that reload.
- R6: `wave_o` is the order-0 result clipped to the range -2048 to 2047.
- R7: In the cubic profile, `beam_scale_i` is an unsigned Q1.7 factor, where 128 means unity. The sample is floor((acc0 * scale + 64) / 128), clipped as in R6.
- R8: In the cubic profile, `low_z_o` equals `retrace_i` delayed by one clock.
- R9: In a cycle with neither pulse high, every accumulator holds its value.
- R10: The quartic profile uses five accumulators (orders 0 to 4), ignores `beam_scale_i`, and keeps `low_z_o` at 0.
- R11: A write to an address at or above the profile's accumulator count changes no start value. In the cubic profile this applies to address 4 and above; in the quartic profile, to address 5 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start_i | input | 1 | Field-start pulse that reloads the accumulators |
| line_step_i | input | 1 | Line-step pulse that advances the polynomial |
| cfg_we_i | input | 1 | Host write strobe for a start value |
| cfg_addr_i | input | 3 | Polynomial order addressed by the write |
| cfg_wdata_i | input | 12 | Signed start value to store |
| beam_scale_i | input | 8 | Unsigned Q1.7 beam-current scale factor (cubic profile only) |
| retrace_i | input | 1 | High during vertical retrace |
| wave_o | output | 12 | Signed, clipped waveform sample |
| low_z_o | output | 1 | Request for halved output impedance during retrace |

## Verification
Both profiles are driven side by side with identical stimulus, starting with mixed-sign start values on every order.

A long run of line steps drives the cubic term through the positive clip, then through internal wraparound into the negative clip. This separates a correct three-level carry chain, and the clipping, from a design that wraps at the output or updates the accumulators in sequence.

A write to order 4 separates the two profiles. The cubic output must stay unchanged while the quartic output bends. Mid-field writes, and field starts that coincide with a step or a write, expose reload-priority and shadowing faults. A sweep of scale factors below, at and above unity, applied to values of both signs, checks the rounding. Irregular retrace pulses check the one-cycle impedance timing.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    typedef enum logic {
        PROF_CUBIC   = 1'b0,
        PROF_QUARTIC = 1'b1
    } prof_e;

    localparam int DEF_DATA_W     = 12;
    localparam int DEF_GUARD_W    = 8;
    localparam int DEF_ADDR_W     = 3;
    localparam int DEF_SCALE_W    = 8;
    localparam int DEF_SCALE_FRAC = 7;

    function automatic int acc_count(prof_e p);
        return (p == PROF_QUARTIC) ? 5 : 4;
    endfunction

endpackage

// File: rtl/pwg_start_regs.sv
module pwg_start_regs #(
    parameter int NUM    = 4,
    parameter int DATA_W = 12,
    parameter int ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [NUM-1:0][DATA_W-1:0]    start_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM - 1);

    typedef struct packed {
        logic [NUM-1:0][DATA_W-1:0] val;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int k = 0; k < NUM; k++) begin
            if (we_i && (addr_i == ADDR_W'(k))) begin
                regs_d.val[k] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign start_o = regs_q.val;

    // R11: out-of-range addresses leave every start value untouched
    assert_addr_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (addr_i > LAST_ADDR)) |=> $stable(start_o));

endmodule

// File: rtl/pwg_acc_chain.sv
module pwg_acc_chain #(
    parameter int NUM    = 4,
    parameter int DATA_W = 12,
    parameter int ACC_W  = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          field_start_i,
    input  logic                          step_i,
    input  logic [NUM-1:0][DATA_W-1:0]    start_i,
    output logic signed [ACC_W-1:0]       acc0_o
);

    localparam int GUARD_W = ACC_W - DATA_W;

    typedef struct packed {
        logic [NUM-1:0][ACC_W-1:0] acc;
    } chain_t;

    chain_t chain_d, chain_q;

    function automatic logic [ACC_W-1:0] sext(input logic [DATA_W-1:0] v);
        return {{GUARD_W{v[DATA_W-1]}}, v};
    endfunction

    always_comb begin
        chain_d = chain_q;
        if (field_start_i) begin
            for (int k = 0; k < NUM; k++) begin
                chain_d.acc[k] = sext(start_i[k]);
            end
        end else if (step_i) begin
            for (int k = 0; k < NUM - 1; k++) begin
                chain_d.acc[k] = chain_q.acc[k] + chain_q.acc[k+1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign acc0_o = signed'(chain_q.acc[0]);

    // R9: no pulse means no movement anywhere in the chain
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!field_start_i && !step_i) |=> $stable(chain_q));

    // R2: the top order is loaded from its start register
    assert_load_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        field_start_i |=> (chain_q.acc[NUM-1] == sext($past(start_i[NUM-1]))));

    // R3: the highest order is constant across a step
    assert_top_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !field_start_i) |=> $stable(chain_q.acc[NUM-1]));

    // R3: order 0 absorbs the old order-1 value
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !field_start_i) |=>
            (chain_q.acc[0] == $past(chain_q.acc[0]) + $past(chain_q.acc[1])));

endmodule

// File: rtl/pwg_out_stage.sv
module pwg_out_stage #(
    parameter int ACC_W      = 20,
    parameter int DATA_W     = 12,
    parameter int SCALE_W    = 8,
    parameter int SCALE_FRAC = 7,
    parameter bit USE_SCALE  = 1'b1
) (
    input  logic signed [ACC_W-1:0]   acc0_i,
    input  logic [SCALE_W-1:0]        scale_i,
    output logic signed [DATA_W-1:0]  wave_o
);

    localparam int PROD_W = ACC_W + SCALE_W + 1;
    localparam int SHR_W  = PROD_W - SCALE_FRAC;
    localparam logic signed [SHR_W-1:0] MAXV = SHR_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [SHR_W-1:0] MINV = -SHR_W'(1 << (DATA_W - 1));

    logic signed [SHR_W-1:0] pre_clip;

    generate
        if (USE_SCALE) begin : g_scaled
            logic signed [PROD_W-1:0] prod;
            logic signed [PROD_W-1:0] rounded;
            always_comb begin
                prod     = PROD_W'(acc0_i) * PROD_W'(signed'({1'b0, scale_i}));
                rounded  = prod + PROD_W'(1 << (SCALE_FRAC - 1));
                pre_clip = SHR_W'(rounded >>> SCALE_FRAC);
            end
        end else begin : g_plain
            logic unused_scale;
            assign unused_scale = ^scale_i;
            assign pre_clip = SHR_W'(acc0_i);
        end
    endgenerate

    always_comb begin
        if (pre_clip > MAXV) begin
            wave_o = MAXV[DATA_W-1:0];
        end else if (pre_clip < MINV) begin
            wave_o = MINV[DATA_W-1:0];
        end else begin
            wave_o = pre_clip[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/pwg_deflect_gen.sv
module pwg_deflect_gen
    import pwg_pkg::*;
#(
    parameter prof_e PROFILE    = PROF_CUBIC,
    parameter int    DATA_W     = DEF_DATA_W,
    parameter int    GUARD_W    = DEF_GUARD_W,
    parameter int    ADDR_W     = DEF_ADDR_W,
    parameter int    SCALE_W    = DEF_SCALE_W,
    parameter int    SCALE_FRAC = DEF_SCALE_FRAC
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      field_start_i,
    input  logic                      line_step_i,
    input  logic                      cfg_we_i,
    input  logic [ADDR_W-1:0]         cfg_addr_i,
    input  logic [DATA_W-1:0]         cfg_wdata_i,
    input  logic [SCALE_W-1:0]        beam_scale_i,
    input  logic                      retrace_i,
    output logic signed [DATA_W-1:0]  wave_o,
    output logic                      low_z_o
);

    localparam int NUM       = acc_count(PROFILE);
    localparam int ACC_W     = DATA_W + GUARD_W;
    localparam bit IS_CUBIC  = (PROFILE == PROF_CUBIC);
    localparam logic [SCALE_W-1:0] UNITY = SCALE_W'(1 << SCALE_FRAC);
    localparam logic signed [ACC_W-1:0] MAXA = ACC_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINA = -ACC_W'(1 << (DATA_W - 1));

    typedef struct packed {
        logic low_z;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM-1:0][DATA_W-1:0] start_vals;
    logic signed [ACC_W-1:0]    acc0;

    pwg_start_regs #(
        .NUM    (NUM),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_start_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .start_o (start_vals)
    );

    pwg_acc_chain #(
        .NUM    (NUM),
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
    ) u_acc_chain (
        .clk           (clk),
        .rst_n         (rst_n),
        .field_start_i (field_start_i),
        .step_i        (line_step_i),
        .start_i       (start_vals),
        .acc0_o        (acc0)
    );

    pwg_out_stage #(
        .ACC_W      (ACC_W),
        .DATA_W     (DATA_W),
        .SCALE_W    (SCALE_W),
        .SCALE_FRAC (SCALE_FRAC),
        .USE_SCALE  (IS_CUBIC)
    ) u_out_stage (
        .acc0_i  (acc0),
        .scale_i (beam_scale_i),
        .wave_o  (wave_o)
    );

    always_comb begin
        st_d       = st_q;
        st_d.low_z = IS_CUBIC ? retrace_i : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign low_z_o = st_q.low_z;

    // R8 / R10: impedance request follows retrace only in the cubic profile
    assert_low_z_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (low_z_o == (IS_CUBIC && $past(retrace_i))));

    // R6: unscaled order-0 values above range clip to the top code
    assert_clip_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!IS_CUBIC || beam_scale_i == UNITY) && (acc0 > MAXA)) |->
            (wave_o == MAXA[DATA_W-1:0]));

    // R6: unscaled order-0 values below range clip to the bottom code
    assert_clip_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!IS_CUBIC || beam_scale_i == UNITY) && (acc0 < MINA)) |->
            (wave_o == MINA[DATA_W-1:0]));

endmodule

// File: tb/pwg_deflect_gen_bench.sv
`timescale 1ns/1ps
module pwg_deflect_gen_bench;
    import pwg_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              field_start = 1'b0, line_step = 1'b0, cfg_we = 1'b0, retrace = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [11:0]       cfg_wdata = '0;
    logic [7:0]        scale = 8'd128;
    logic signed [11:0] wave_v, wave_e;
    logic              lowz_v, lowz_e;

    pwg_deflect_gen #(.PROFILE(PROF_CUBIC)) u_pwg_deflect_gen (
        .clk(clk), .rst_n(rst_n), .field_start_i(field_start), .line_step_i(line_step),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .beam_scale_i(scale), .retrace_i(retrace), .wave_o(wave_v), .low_z_o(lowz_v));

    pwg_deflect_gen #(.PROFILE(PROF_QUARTIC)) u_pwg_deflect_gen_ew (
        .clk(clk), .rst_n(rst_n), .field_start_i(field_start), .line_step_i(line_step),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .beam_scale_i(scale), .retrace_i(retrace), .wave_o(wave_e), .low_z_o(lowz_e));

    int     vectors = 0, miscompares = 0;
    bit     done = 1'b0;
    string  phase = "R1";
    longint sv[5], se[5], av[5], ae[5];
    int     lowz_exp = 0;

    function automatic longint wrap20(longint v);
        longint m = v & longint'(20'hFFFFF);
        if (m >= 524288) m -= 1048576;
        return m;
    endfunction

    function automatic int clip12(longint v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return int'(v);
    endfunction

    function automatic int scaled(longint a, int s);
        longint p = a * s + 64;
        return clip12(p >>> 7);
    endfunction

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    task automatic tick(bit fs, bit st, bit we, int addr, int data, bit ret);
        @(negedge clk);
        check({phase, " cubic wave"},   int'(wave_v), scaled(av[0], int'(scale)));
        check({phase, " cubic low_z"},  int'(lowz_v), lowz_exp);
        check({phase, " quartic wave"}, int'(wave_e), clip12(ae[0]));
        check({phase, " quartic low_z R10"}, int'(lowz_e), 0);
        field_start = fs; line_step = st; cfg_we = we;
        cfg_addr = 3'(addr); cfg_wdata = 12'(data); retrace = ret;
        if (fs) begin
            for (int k = 0; k < 5; k++) begin av[k] = sv[k]; ae[k] = se[k]; end
        end else if (st) begin
            for (int k = 0; k < 4; k++) begin
                if (k < 3) av[k] = wrap20(av[k] + av[k+1]);
                ae[k] = wrap20(ae[k] + ae[k+1]);
            end
        end
        if (we) begin
            if (addr < 4) sv[addr] = data;
            if (addr < 5) se[addr] = data;
        end
        lowz_exp = ret;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) tick(0, 1, 0, 0, 0, 0);
    endtask

    task automatic wr(int addr, int data);
        tick(0, 0, 1, addr, data, 0);
    endtask

    initial begin
        for (int k = 0; k < 5; k++) begin sv[k] = 0; se[k] = 0; av[k] = 0; ae[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        idle(2);
        tick(1, 0, 0, 0, 0, 0);
        idle(2);
        phase = "R2";
        wr(0, -300); wr(1, 40); wr(2, 3); wr(3, 1);
        phase = "R11";
        wr(4, 2); wr(6, 777); wr(7, -5);
        phase = "R2";
        tick(1, 0, 0, 0, 0, 0);
        idle(1);
        phase = "R9";
        idle(3);
        phase = "R3";
        for (int i = 0; i < 30; i++) begin tick(0, 1, 0, 0, 0, 0); tick(0, 0, 0, 0, 0, 0); end
        phase = "R6";
        steps(280);
        phase = "R5";
        tick(1, 0, 0, 0, 0, 0);
        steps(4);
        wr(0, 500); wr(2, -7);
        steps(6);
        tick(1, 0, 1, 1, -90, 0);
        steps(8);
        tick(1, 0, 0, 0, 0, 0);
        steps(5);
        phase = "R4";
        wr(1, 11); wr(3, -2); wr(4, -1);
        tick(1, 1, 0, 0, 0, 0);
        steps(3);
        tick(1, 1, 0, 0, 0, 0);
        idle(2);
        phase = "R7";
        wr(0, -1000); wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 0);
        tick(1, 0, 0, 0, 0, 0);
        foreach (sv[i]) begin end
        scale = 8'd64;  idle(2);
        scale = 8'd200; idle(2);
        scale = 8'd0;   idle(2);
        scale = 8'd255; idle(2);
        scale = 8'd3;   idle(2);
        wr(0, 1999); wr(1, 5);
        tick(1, 0, 0, 0, 0, 0);
        scale = 8'd255; steps(3);
        scale = 8'd97;  steps(3);
        scale = 8'd128;
        phase = "R8";
        tick(0, 0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 1); tick(0, 1, 0, 0, 0, 0); tick(0, 0, 0, 0, 0, 1);
        idle(2);
        phase = "R10";
        wr(0, 100); wr(1, -20); wr(2, 6); wr(3, -1); wr(4, 1);
        tick(1, 0, 0, 0, 0, 0);
        scale = 8'd50;
        steps(40);
        scale = 8'd128;
        idle(1);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=still running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule